// File: doc/BRIEF.md
# Serial-Flash Linear Read-Ahead Engine

The engine reads a contiguous block of serial flash with no processor involvement per byte. Software sets a start address, a length in 32-bit words, an 8-bit read opcode, a lane width for each of the command, address and data phases, a dummy-cycle count and a choice of 3-byte or 4-byte addressing. It then writes the start bit. The engine drives one chip select through a command, address, dummy and data sequence. It packs the received bytes into little-endian words and queues them in a 16-word FIFO. Software drains the FIFO by reading a data register.

An ownership bit hands the flash pins either to this engine or to a separate direct SPI master whose pin signals enter the block. Software watches the engine's busy flag before it moves the pins between the two. While the FIFO is full the engine holds SCK low, so the flash simply waits and no data is dropped.

The sequencer is a state machine with six states. IDLE goes to CMD on an accepted start. CMD goes to ADDR after 8 opcode bits. ADDR goes to DUMMY after the address bits when the dummy count is nonzero, and otherwise goes straight to DATA. DUMMY goes to DATA after the dummy cycles. DATA goes to END after the last word is pushed. END goes back to IDLE after one cycle with chip select high. Each bit cell lasts two clocks: SCK is low in the first and high in the second. Input is sampled as SCK rises.

Top module: `flash_readahead`

## Requirements
- R1: After reset the status register reads 2 (not busy, FIFO empty), the ownership register reads 0, flash chip select is high and flash SCK is low.
- R2: A write of 1 to bit 0 of the control register (index 2) starts a session only when the engine is idle, the engine owns the pins and the word count (index 1) is nonzero. In every other case the write is ignored.
- R3: A session keeps chip select low throughout. It sends the opcode (index 5, bits [7:0]) first as 8 bits, then the address, then the dummy cycles, then the data. SCK idles low and input is sampled on its rising edge.
- R4: The lane register (index 6) holds a data width code at bits [1:0], an address code at [17:16] and a command code at [25:24]. Code 0 means one lane (output on io0, input on io1), 1 means two lanes on io[1:0], and 2 or 3 mean four lanes. Bits go out MSB first, with the highest-numbered lane carrying the most significant bit. Output enables are set exactly on the lanes of the current output phase.
- R5: The start register (index 0) keeps only address bits [23:0]. With phase register bit 16 clear, 24 address bits are sent. With it set, 32 bits are sent: bits [31:24] of the upper-byte register (index 8) first, then the 24 start bits.
- R6: The phase register bits [7:0] give a number of dummy SCK cycles. During these cycles all flash output enables are low.
- R7: Each FIFO word holds four consecutive received bytes, with the first byte in bits [7:0] and the fourth in bits [31:24].
- R8: A session delivers exactly the programmed number of words. Chip select then rises and the busy flag clears.
- R9: The FIFO holds 16 words. While it is full, SCK stays low and the session stays busy. The session resumes without loss once words are read.
- R10: The status register (index 3) shows the session-busy flag in bit 0 and the FIFO-empty flag in bit 1.
- R11: A read of the data register (index 4) pops one word. When the FIFO is empty the read returns 0 and changes nothing.
- R12: The ownership register (index 9) bit 0 selects the direct master's pins (1) or the engine (0). A write to it while the engine is busy is ignored. The pin-busy register (index 10) bit 0 reads 1 while the engine drives the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO when it addresses the data register |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| dm_sck | input | 1 | Direct master SCK |
| dm_cs_n | input | 1 | Direct master chip select |
| dm_io_out | input | 4 | Direct master lane outputs |
| dm_io_oe | input | 4 | Direct master lane enables |
| flash_sck | output | 1 | Flash SCK |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_io_out | output | 4 | Flash lane outputs |
| flash_io_oe | output | 4 | Flash lane output enables |
| flash_io_in | input | 4 | Flash lane inputs |

## Verification
A bit counter or phase state that goes wrong inside the sequencer changes the number of SCK rising edges in a session. It also moves the cell at which the output enables fall. Both are visible on the pins within one bit cell of the error, and the total edge count at the end of the session no longer matches the value computed from the programmed configuration. A wrong byte index or shift width corrupts the first word read from the FIFO, which is compared with bytes derived from the captured address. A full-flag error shows up while the FIFO is held full: SCK rises again and the queued data either overruns or loses words.

// File: rtl/flr_pkg.sv
package flr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_END
    } seq_state_e;

    localparam logic [3:0] REG_START   = 4'd0;
    localparam logic [3:0] REG_WORDS   = 4'd1;
    localparam logic [3:0] REG_CTRL    = 4'd2;
    localparam logic [3:0] REG_STATUS  = 4'd3;
    localparam logic [3:0] REG_DATA    = 4'd4;
    localparam logic [3:0] REG_OPCODE  = 4'd5;
    localparam logic [3:0] REG_LANES   = 4'd6;
    localparam logic [3:0] REG_PHASE   = 4'd7;
    localparam logic [3:0] REG_UPPER   = 4'd8;
    localparam logic [3:0] REG_OWNER   = 4'd9;
    localparam logic [3:0] REG_PINBUSY = 4'd10;

    // width code 3 behaves as four lanes
    function automatic logic [1:0] lane_eff(input logic [1:0] code);
        return (code > 2'd1) ? 2'd2 : code;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] w);
        return (w == 2'd0) ? 4'b0001 : (w == 2'd1) ? 4'b0011 : 4'b1111;
    endfunction

endpackage

// File: rtl/flr_fifo.sv
module flr_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= push_data;
                wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rptr];
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_fill_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);

endmodule

// File: rtl/flr_seq.sv
module flr_seq
    import flr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DUMMY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [31:0]      addr,
    input  logic             addr4,
    input  logic [1:0]       lw_cmd,
    input  logic [1:0]       lw_addr,
    input  logic [1:0]       lw_data,
    input  logic [DUMMY_W-1:0] dummy,
    input  logic [CNT_W-1:0] nwords,
    input  logic             fifo_full,
    input  logic [3:0]       io_in,
    output logic             sck,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic             push,
    output logic [31:0]      push_word,
    output logic             busy
);
    localparam int CELL_W = (DUMMY_W > 6) ? DUMMY_W : 6;

    seq_state_e         state;
    logic               half;
    logic [31:0]        sr, addr_q;
    logic [CELL_W-1:0]  cells;
    logic [CNT_W-1:0]   words;
    logic [1:0]         byte_idx, wc_q, wa_q, wd_q;
    logic               a4_q;
    logic [DUMMY_W-1:0] dummy_q;
    logic [7:0]         rx_byte, rx_next;
    logic [23:0]        acc;
    logic [1:0]         cur_w;
    logic [CELL_W-1:0]  byte_cells;

    assign cur_w      = (state == ST_CMD) ? wc_q : (state == ST_ADDR) ? wa_q : wd_q;
    assign byte_cells = CELL_W'(8) >> wd_q;

    always_comb begin
        unique case (wd_q)
            2'd0:    rx_next = {rx_byte[6:0], io_in[1]};
            2'd1:    rx_next = {rx_byte[5:0], io_in[1:0]};
            default: rx_next = {rx_byte[3:0], io_in};
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   half <= 1'b0;  sr <= '0;   addr_q <= '0;
            cells <= '0;        words <= '0;   byte_idx <= '0;
            wc_q <= '0; wa_q <= '0; wd_q <= '0; a4_q <= 1'b0; dummy_q <= '0;
            rx_byte <= '0;      acc <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    wc_q     <= lane_eff(lw_cmd);
                    wa_q     <= lane_eff(lw_addr);
                    wd_q     <= lane_eff(lw_data);
                    a4_q     <= addr4;
                    dummy_q  <= dummy;
                    addr_q   <= addr4 ? addr : {addr[23:0], 8'h00};
                    sr       <= {opcode, 24'h0};
                    cells    <= CELL_W'(8) >> lane_eff(lw_cmd);
                    words    <= nwords;
                    byte_idx <= '0;
                    half     <= 1'b0;
                    state    <= ST_CMD;
                end
                ST_CMD, ST_ADDR, ST_DUMMY: begin
                    if (!half) begin
                        half <= 1'b1;
                    end else begin
                        half  <= 1'b0;
                        sr    <= sr << (6'd1 << cur_w);
                        cells <= cells - 1'b1;
                        if (cells == CELL_W'(1)) begin
                            if (state == ST_CMD) begin
                                sr    <= addr_q;
                                cells <= (a4_q ? CELL_W'(32) : CELL_W'(24)) >> wa_q;
                                state <= ST_ADDR;
                            end else if (state == ST_ADDR && dummy_q != '0) begin
                                cells <= CELL_W'(dummy_q);
                                state <= ST_DUMMY;
                            end else begin
                                cells <= byte_cells;
                                state <= ST_DATA;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (!half) begin
                        if (!fifo_full) begin
                            half    <= 1'b1;
                            rx_byte <= rx_next;
                        end
                    end else begin
                        half  <= 1'b0;
                        cells <= cells - 1'b1;
                        if (cells == CELL_W'(1)) begin
                            cells    <= byte_cells;
                            byte_idx <= byte_idx + 1'b1;
                            unique case (byte_idx)
                                2'd0: acc[7:0]   <= rx_byte;
                                2'd1: acc[15:8]  <= rx_byte;
                                2'd2: acc[23:16] <= rx_byte;
                                default: begin
                                    words <= words - 1'b1;
                                    if (words == CNT_W'(1)) state <= ST_END;
                                end
                            endcase
                        end
                    end
                end
                ST_END:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        cs_n      = (state == ST_IDLE) || (state == ST_END);
        sck       = half;
        push      = (state == ST_DATA) && half && (cells == CELL_W'(1)) && (byte_idx == 2'd3);
        push_word = {rx_byte, acc};
        unique case (state)
            ST_CMD:  io_oe = lane_mask(wc_q);
            ST_ADDR: io_oe = lane_mask(wa_q);
            default: io_oe = 4'b0000;
        endcase
        unique case (cur_w)
            2'd0:    io_out = {3'b000, sr[31]};
            2'd1:    io_out = {2'b00, sr[31:30]};
            default: io_out = sr[31:28];
        endcase
    end

    assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

endmodule

// File: rtl/flr_pinmux.sv
module flr_pinmux (
    input  logic       sel_direct,
    input  logic       eng_sck,
    input  logic       eng_cs_n,
    input  logic [3:0] eng_io_out,
    input  logic [3:0] eng_io_oe,
    input  logic       dm_sck,
    input  logic       dm_cs_n,
    input  logic [3:0] dm_io_out,
    input  logic [3:0] dm_io_oe,
    output logic       pin_sck,
    output logic       pin_cs_n,
    output logic [3:0] pin_io_out,
    output logic [3:0] pin_io_oe
);
    always_comb begin
        if (sel_direct) begin
            pin_sck = dm_sck;   pin_cs_n = dm_cs_n;
            pin_io_out = dm_io_out; pin_io_oe = dm_io_oe;
        end else begin
            pin_sck = eng_sck;  pin_cs_n = eng_cs_n;
            pin_io_out = eng_io_out; pin_io_oe = eng_io_oe;
        end
    end
endmodule

// File: rtl/flash_readahead.sv
module flash_readahead
    import flr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    parameter int DUMMY_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dm_sck,
    input  logic        dm_cs_n,
    input  logic [3:0]  dm_io_out,
    input  logic [3:0]  dm_io_oe,
    output logic        flash_sck,
    output logic        flash_cs_n,
    output logic [3:0]  flash_io_out,
    output logic [3:0]  flash_io_oe,
    input  logic [3:0]  flash_io_in
);
    logic [23:0]        start_q;
    logic [CNT_W-1:0]   words_q;
    logic [7:0]         op_q, upper_q;
    logic [1:0]         lc_q, la_q, ld_q;
    logic [DUMMY_W-1:0] dummy_q;
    logic               a4_q, owner_q;
    logic               seq_busy, seq_start, push, pop, full, empty;
    logic [31:0]        push_word, head;
    logic               e_sck, e_cs_n;
    logic [3:0]         e_io_out, e_io_oe;
    logic               wdata_unused;

    assign wdata_unused = ^reg_wdata;
    assign seq_start = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0]
                       && !seq_busy && !owner_q && (words_q != '0);
    assign pop = reg_rd && (reg_addr == REG_DATA) && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0; words_q <= '0; op_q <= '0; upper_q <= '0;
            lc_q <= '0; la_q <= '0; ld_q <= '0; dummy_q <= '0;
            a4_q <= 1'b0; owner_q <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                REG_START:  start_q <= reg_wdata[23:0];
                REG_WORDS:  words_q <= reg_wdata[CNT_W-1:0];
                REG_OPCODE: op_q    <= reg_wdata[7:0];
                REG_LANES:  begin
                    ld_q <= reg_wdata[1:0];
                    la_q <= reg_wdata[17:16];
                    lc_q <= reg_wdata[25:24];
                end
                REG_PHASE:  begin
                    dummy_q <= reg_wdata[DUMMY_W-1:0];
                    a4_q    <= reg_wdata[16];
                end
                REG_UPPER:  upper_q <= reg_wdata[31:24];
                REG_OWNER:  if (!seq_busy) owner_q <= reg_wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_START:   reg_rdata = {8'h00, start_q};
            REG_WORDS:   reg_rdata = 32'(words_q);
            REG_STATUS:  reg_rdata = {30'h0, empty, seq_busy};
            REG_DATA:    reg_rdata = empty ? 32'h0 : head;
            REG_OPCODE:  reg_rdata = {24'h0, op_q};
            REG_LANES:   reg_rdata = {6'h0, lc_q, 6'h0, la_q, 14'h0, ld_q};
            REG_PHASE:   reg_rdata = {15'h0, a4_q, 16'(dummy_q)};
            REG_UPPER:   reg_rdata = {upper_q, 24'h0};
            REG_OWNER:   reg_rdata = {31'h0, owner_q};
            REG_PINBUSY: reg_rdata = {31'h0, seq_busy};
            default:     reg_rdata = 32'h0;
        endcase
    end

    flr_seq #(.CNT_W(CNT_W), .DUMMY_W(DUMMY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .opcode(op_q),
        .addr({upper_q, start_q}), .addr4(a4_q),
        .lw_cmd(lc_q), .lw_addr(la_q), .lw_data(ld_q),
        .dummy(dummy_q), .nwords(words_q), .fifo_full(full),
        .io_in(flash_io_in), .sck(e_sck), .cs_n(e_cs_n),
        .io_out(e_io_out), .io_oe(e_io_oe),
        .push(push), .push_word(push_word), .busy(seq_busy)
    );

    flr_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_word),
        .pop(pop), .head(head), .full(full), .empty(empty)
    );

    flr_pinmux u_mux (
        .sel_direct(owner_q), .eng_sck(e_sck), .eng_cs_n(e_cs_n),
        .eng_io_out(e_io_out), .eng_io_oe(e_io_oe),
        .dm_sck(dm_sck), .dm_cs_n(dm_cs_n), .dm_io_out(dm_io_out), .dm_io_oe(dm_io_oe),
        .pin_sck(flash_sck), .pin_cs_n(flash_cs_n),
        .pin_io_out(flash_io_out), .pin_io_oe(flash_io_oe)
    );

    assert_owner_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> $stable(owner_q));

    assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0] && !owner_q));

endmodule

// File: tb/flash_readahead_tb.sv
module flash_readahead_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dm_sck = 1'b0, dm_cs_n = 1'b1;
    logic [3:0]  dm_io_out = '0, dm_io_oe = '0;
    logic        flash_sck, flash_cs_n;
    logic [3:0]  flash_io_out, flash_io_oe;
    logic [3:0]  flash_io_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_readahead u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dm_sck(dm_sck), .dm_cs_n(dm_cs_n), .dm_io_out(dm_io_out), .dm_io_oe(dm_io_oe),
        .flash_sck(flash_sck), .flash_cs_n(flash_cs_n),
        .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int          n = 0;
    int          m_cc = 8, m_ca = 24, m_cd = 0, m_wc = 0, m_wa = 0, m_wd = 0;
    logic [31:0] cmd_acc = '0, addr_acc = '0;
    int          oe_err = 0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'd37) ^ (a >> 8) ^ ((a >> 16) * 32'd5) ^ ((a >> 24) * 32'd11);
        return h[7:0];
    endfunction

    function automatic logic [3:0] lmask(input int w);
        return (w == 0) ? 4'b0001 : (w == 1) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] lbits(input logic [3:0] io, input int w);
        return (w == 0) ? {31'h0, io[0]} : (w == 1) ? {30'h0, io[1:0]} : {28'h0, io};
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a, input int k);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = mem_byte(a + 32'(4*k + i));
        return r;
    endfunction

    always @(posedge flash_sck) begin
        if (n < m_cc) begin
            if (flash_io_oe !== lmask(m_wc)) oe_err++;
            cmd_acc = (cmd_acc << (1 << m_wc)) | lbits(flash_io_out, m_wc);
        end else if (n < m_cc + m_ca) begin
            if (flash_io_oe !== lmask(m_wa)) oe_err++;
            addr_acc = (addr_acc << (1 << m_wa)) | lbits(flash_io_out, m_wa);
        end else if (flash_io_oe !== 4'b0000) begin
            oe_err++;
        end
        n++;
    end

    always @(n or addr_acc or m_cc or m_ca or m_cd or m_wd) begin
        int base, d, cpb, bw, sh;
        logic [7:0] b, v;
        base = m_cc + m_ca + m_cd;
        flash_io_in = 4'b0000;
        if (n >= base) begin
            d   = n - base;
            bw  = 1 << m_wd;
            cpb = 8 / bw;
            b   = mem_byte(addr_acc + 32'(d / cpb));
            sh  = 8 - bw * ((d % cpb) + 1);
            v   = (b >> sh) & 8'((1 << bw) - 1);
            flash_io_in = (m_wd == 0) ? {2'b00, v[0], 1'b0} : v[3:0];
        end
    end

    // ---------------- register access ----------------
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic run_session(input logic [7:0] op, input logic [31:0] start_in,
                               input logic [7:0] upper, input bit a4,
                               input int wc, input int wa, input int wd,
                               input int dummy, input int words, input bit probe);
        logic [31:0] d, exp_addr;
        int ewc, ewa, ewd, total;
        ewc = (wc >= 2) ? 2 : wc;
        ewa = (wa >= 2) ? 2 : wa;
        ewd = (wd >= 2) ? 2 : wd;
        reg_write(4'd0, start_in);
        reg_write(4'd1, 32'(words));
        reg_write(4'd5, {24'h0, op});
        reg_write(4'd6, 32'(wd) | (32'(wa) << 16) | (32'(wc) << 24));
        reg_write(4'd7, 32'(dummy) | (32'(a4) << 16));
        reg_write(4'd8, {upper, 24'h0});
        m_cc = 8 >> ewc; m_ca = (a4 ? 32 : 24) >> ewa; m_cd = dummy; m_wc = ewc; m_wa = ewa; m_wd = ewd;
        n = 0; cmd_acc = '0; addr_acc = '0; oe_err = 0;
        exp_addr = a4 ? {upper, start_in[23:0]} : {8'h00, start_in[23:0]};
        total = m_cc + m_ca + m_cd + words * (32 >> ewd);
        reg_write(4'd2, 32'h1);
        reg_read(4'd3, d);
        check(d[0] == 1'b1, "R10", "busy after start", 64'(d), 64'h1);
        reg_write(4'd2, 32'h1);           // R2: start while busy is ignored
        if (probe) begin
            reg_write(4'd9, 32'h1);
            reg_read(4'd9, d);
            check(d[0] == 1'b0, "R12", "owner write while busy", 64'(d), 64'h0);
            reg_read(4'd10, d);
            check(d[0] == 1'b1, "R12", "pin busy flag", 64'(d), 64'h1);
        end
        if (words > 16) begin
            repeat (1500) @(negedge clk);
            check(n == m_cc + m_ca + m_cd + 16 * (32 >> ewd), "R9", "sck edges when full",
                  64'(n), 64'(m_cc + m_ca + m_cd + 16 * (32 >> ewd)));
            check(flash_sck == 1'b0, "R9", "sck held low", 64'(flash_sck), 64'h0);
            reg_read(4'd3, d);
            check(d[0] == 1'b1, "R9", "busy while stalled", 64'(d), 64'h1);
        end else begin
            for (int t = 0; t < 4000; t++) begin
                reg_read(4'd3, d);
                if (d[0] == 1'b0) break;
            end
            check(flash_cs_n == 1'b1, "R8", "cs high at end", 64'(flash_cs_n), 64'h1);
        end
        check(cmd_acc[7:0] == op, "R3", "opcode bits", 64'(cmd_acc), 64'(op));
        check(addr_acc == exp_addr, "R5", "address bits", 64'(addr_acc), 64'(exp_addr));
        for (int k = 0; k < words; k++) begin
            for (int t = 0; t < 4000; t++) begin
                reg_read(4'd3, d);
                if (d[1] == 1'b0) break;
            end
            reg_read(4'd4, d);
            check(d == exp_word(exp_addr, k), "R7", "fifo word", 64'(d), 64'(exp_word(exp_addr, k)));
        end
        for (int t = 0; t < 4000; t++) begin
            reg_read(4'd3, d);
            if (d[0] == 1'b0) break;
        end
        check(oe_err == 0, "R4", "output enables per phase (R6 dummy)", 64'(oe_err), 64'h0);
        check(n == total, "R8", "total sck edges (R6 dummy count)", 64'(n), 64'(total));
        check(d == 32'h2, "R8", "status idle and empty", 64'(d), 64'h2);
        reg_read(4'd4, d);
        check(d == 32'h0, "R11", "data read when empty", 64'(d), 64'h0);
    endtask

    // ---------------- main ----------------
    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        reg_read(4'd3, d);
        check(d == 32'h2, "R1", "status after reset", 64'(d), 64'h2);
        check(flash_cs_n == 1'b1 && flash_sck == 1'b0, "R1", "pins after reset",
              64'({flash_cs_n, flash_sck}), 64'h2);
        reg_read(4'd9, d);
        check(d == 32'h0, "R1", "owner after reset", 64'(d), 64'h0);

        reg_read(4'd4, d);
        check(d == 32'h0, "R11", "empty pop value", 64'(d), 64'h0);
        reg_read(4'd3, d);
        check(d == 32'h2, "R11", "status after empty pop", 64'(d), 64'h2);

        reg_write(4'd1, 32'h0);
        reg_write(4'd2, 32'h1);
        reg_read(4'd3, d);
        check(d[0] == 1'b0, "R2", "start with zero words", 64'(d), 64'h2);

        reg_write(4'd9, 32'h1);
        dm_sck = 1'b1; dm_cs_n = 1'b0; dm_io_out = 4'hA; dm_io_oe = 4'h5;
        #1;
        check({flash_sck, flash_cs_n, flash_io_out, flash_io_oe} == {1'b1, 1'b0, 4'hA, 4'h5},
              "R12", "direct master drives pins",
              64'({flash_sck, flash_cs_n, flash_io_out, flash_io_oe}), 64'({1'b1, 1'b0, 4'hA, 4'h5}));
        reg_write(4'd1, 32'h2);
        reg_write(4'd2, 32'h1);
        reg_read(4'd10, d);
        check(d[0] == 1'b0, "R2", "start while direct master owns", 64'(d), 64'h0);
        dm_sck = 1'b0; dm_cs_n = 1'b1; dm_io_out = 4'h0; dm_io_oe = 4'h0;
        reg_write(4'd9, 32'h0);
        #1;
        check(flash_cs_n == 1'b1 && flash_io_oe == 4'h0, "R12", "engine owns idle pins",
              64'({flash_cs_n, flash_io_oe}), 64'h10);

        // directed: single lane, 3-byte address, high start bits discarded
        run_session(8'h03, 32'hAB123456, 8'h00, 1'b0, 0, 0, 0, 0, 3, 1'b1);
        // directed: four lanes (command code 3), 4-byte address, dummy cycles
        run_session(8'hEC, 32'hFF00FFFC, 8'h7C, 1'b1, 3, 2, 2, 6, 5, 1'b0);
        // directed: two lanes, FIFO filled exactly
        run_session(8'hBB, 32'h00FFFFF0, 8'h11, 1'b0, 1, 1, 1, 8, 16, 1'b0);
        // directed: stall with FIFO full
        run_session(8'h0B, 32'h00000100, 8'h00, 1'b0, 0, 0, 0, 0, 20, 1'b0);

        for (int r = 0; r < 6; r++) begin
            run_session(8'($urandom), $urandom, 8'($urandom), 1'($urandom),
                        int'($urandom % 3), int'($urandom % 3), int'($urandom % 3),
                        ($urandom % 2 == 0) ? 0 : int'($urandom % 16),
                        int'($urandom % 8) + 1, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule